// File: doc/BRIEF.md
# Dual-Channel 2x Interpolator with Interleaved Input

The block takes one 10-bit sample bus on which in-phase (I) and quadrature (Q) words arrive alternately, and turns it into two parallel streams running at twice their input rate. A select line tells the block which channel the word on the bus belongs to. A write strobe tells it whether there is a word at all. An I word is held until its Q partner arrives. The completed pair is then pushed into two identical half-band interpolators, one per channel.

Each interpolator emits two samples per input pair. The first is the stored sample itself. The second is the filtered point halfway to the next one, computed with the kernel (-1, 0, 9, 16, 9, 0, -1)/16. Because a pair needs two bus cycles, each channel's input rate is at most half the clock. The output rate equals the clock. Both channel outputs change on the same edge and share one valid flag.

Top module: `iq_interp2x`

## Requirements
- R1: A synchronous active-low reset clears the held I word, the pairing state and both filter delay lines to zero, drives `i_out` and `q_out` to zero and deasserts `out_valid`.
- R2: When `wr_en` is high and `sel_i` is 1, the bus word is taken as an I word. A later I write before its Q partner replaces the held I word.
- R3: When `wr_en` is high and `sel_i` is 0, the bus word is taken as a Q word. It completes a pair only if an I word is being held. A Q word with no held I word is discarded: `out_valid` stays low and both delay lines are unchanged.
- R4: While `wr_en` is low, the bus and `sel_i` have no effect.
- R5: Let a pair be completed by the Q write sampled at clock edge E. Both outputs then present a new sample with `out_valid` high after edge E+2 and again after edge E+3. The first of these is the word of the pair completed two pairs earlier (zero if there is none yet).
- R6: The sample after edge E+3 is floor((-p0 + 9*p1 + 9*p2 - p3 + 8)/16), computed per channel. Here p0 is the newest pair's word and p1, p2, p3 are the three before it.
- R7: The filtered sample saturates to the range -512..511.
- R8: Whenever `out_valid` is low, `i_out` and `q_out` keep their previous values.
- R9: Pairs written back to back (I, Q, I, Q, ...) keep `out_valid` high on every cycle, so each channel delivers one sample per clock.
- R10: All bus words and outputs are 10-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 10 | Shared I/Q sample word, two's complement |
| wr_en | input | 1 | High when `din` carries a word to capture |
| sel_i | input | 1 | 1: word is I, 0: word is Q |
| i_out | output | 10 | Interpolated I channel sample |
| q_out | output | 10 | Interpolated Q channel sample |
| out_valid | output | 1 | High when both outputs carry a new sample |

## Verification
The assertions assume the bus protocol is met only in the loosest sense: the pairing logic tolerates any mix of I, Q and idle cycles. The properties on pair spacing and output timing depend solely on a pair needing at least two write cycles. The stimulus therefore mixes arbitrary strobe and select patterns, including stray Q words, repeated I words and idle gaps, with dense back-to-back pairs and full-scale words that drive the filtered value into saturation. A mid-stream reset confirms that the delay lines start again from zero.

// File: rtl/iq_interp_pkg.sv
// Package: shared constants and types for the interleaved I/Q 2x interpolator.
// Assumes the half-band kernel (-1, 0, 9, 16, 9, 0, -1) / 16 throughout.
package iq_interp_pkg;
    localparam int HB_TAPS        = 7;   // full kernel length
    localparam int HB_GAIN_SHIFT  = 4;   // divide by 16
    localparam int HB_INNER_COEF  = 9;   // taps adjacent to the centre
    localparam int HB_OUTER_COEF  = -1;  // outermost taps
    localparam int NUM_CHANNELS   = 2;   // I and Q

    // Output phase of one interpolator
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // nothing to emit on the next edge
        PH_LOADED = 2'd1,   // new sample shifted in, emit stored sample next
        PH_MID    = 2'd2    // emit the filtered half-way sample next
    } hb_phase_t;
endpackage

// File: rtl/iq_pair_latch.sv
// Module: iq_pair_latch
// Splits the shared bus into I/Q pairs. An I word is held until a Q word
// arrives; the pair is then presented for one cycle with pair_v high.
// Assumes a Q word without a held I word is to be dropped.
module iq_pair_latch #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         sel_i,
    input  logic [W-1:0] din,
    output logic         pair_v,
    output logic [W-1:0] pair_i,
    output logic [W-1:0] pair_q
);
    logic         i_held;
    logic [W-1:0] i_word;

    // Capture I words, complete pairs on Q words, emit a one-cycle pair pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_held <= 1'b0;
            i_word <= '0;
            pair_v <= 1'b0;
            pair_i <= '0;
            pair_q <= '0;
        end else begin
            pair_v <= 1'b0;
            if (wr_en) begin
                if (sel_i) begin
                    i_word <= din;
                    i_held <= 1'b1;
                end else if (i_held) begin
                    pair_v <= 1'b1;
                    pair_i <= i_word;
                    pair_q <= din;
                    i_held <= 1'b0;
                end
            end
        end
    end

    // R3
    pair_from_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_v |-> $past(wr_en && !sel_i));

    // R9
    pair_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_v |=> !pair_v);
endmodule

// File: rtl/iq_hb_interp.sv
// Module: iq_hb_interp
// One channel of 2x half-band interpolation. Each shift pulse loads a new
// sample; the next two edges emit the stored centre sample, then the
// rounded, saturated midpoint from the four held samples.
// Assumes shift pulses are at least two cycles apart.
module iq_hb_interp
    import iq_interp_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dvalid
);
    localparam int HELD = (HB_TAPS + 1) / 2;          // non-zero polyphase taps
    localparam int AW   = W + HB_GAIN_SHIFT + 2;      // accumulator width
    localparam logic signed [AW-1:0] K_IN  = AW'(HB_INNER_COEF);
    localparam logic signed [AW-1:0] K_OUT = AW'(HB_OUTER_COEF);
    localparam logic signed [AW-1:0] RND   = AW'(1 << (HB_GAIN_SHIFT - 1));
    localparam logic signed [AW-1:0] MAXV  = AW'((1 << (W - 1)) - 1);
    localparam logic signed [AW-1:0] MINV  = AW'(-(1 << (W - 1)));

    logic signed [W-1:0]  tap [HELD];
    hb_phase_t            ph;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] scaled;
    logic signed [W-1:0]  mid_val;

    // Polyphase midpoint: weighted sum, round, scale, saturate
    always_comb begin
        acc    = K_IN  * (AW'(tap[1]) + AW'(tap[2]))
               + K_OUT * (AW'(tap[0]) + AW'(tap[3])) + RND;
        scaled = acc >>> HB_GAIN_SHIFT;
        if (scaled > MAXV)
            mid_val = MAXV[W-1:0];
        else if (scaled < MINV)
            mid_val = MINV[W-1:0];
        else
            mid_val = scaled[W-1:0];
    end

    // Delay line: newest sample at tap[0]
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < HELD; k++) tap[k] <= '0;
        end else if (shift) begin
            tap[0] <= $signed(din);
            for (int k = 1; k < HELD; k++) tap[k] <= tap[k-1];
        end
    end

    // Phase sequencer and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            case (ph)
                PH_LOADED: begin dout <= tap[2];  dvalid <= 1'b1; end
                PH_MID:    begin dout <= mid_val; dvalid <= 1'b1; end
                default:   dvalid <= 1'b0;
            endcase
            if (shift)               ph <= PH_LOADED;
            else if (ph == PH_LOADED) ph <= PH_MID;
            else                     ph <= PH_IDLE;
        end
    end

    // R5
    valid_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> ($past(shift, 2) || $past(shift, 3)));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dvalid && $past(rst_n)) |-> $stable(dout));
endmodule

// File: rtl/iq_interp2x.sv
// Module: iq_interp2x (top)
// Interleaved I/Q bus in, two matched 2x interpolated channels out that
// update on the same edge under one valid flag.
// Assumes the bus carries two's complement words.
module iq_interp2x
    import iq_interp_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_en,
    input  logic              sel_i,
    output logic [DATA_W-1:0] i_out,
    output logic [DATA_W-1:0] q_out,
    output logic              out_valid
);
    logic              pair_v;
    logic [DATA_W-1:0] ch_in  [NUM_CHANNELS];
    logic [DATA_W-1:0] ch_out [NUM_CHANNELS];
    logic              ch_v   [NUM_CHANNELS];

    iq_pair_latch #(.W(DATA_W)) u_pair (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel_i  (sel_i),
        .din    (din),
        .pair_v (pair_v),
        .pair_i (ch_in[0]),
        .pair_q (ch_in[1])
    );

    // One identical interpolator per channel
    for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_chan
        iq_hb_interp #(.W(DATA_W)) u_hb (
            .clk    (clk),
            .rst_n  (rst_n),
            .shift  (pair_v),
            .din    (ch_in[c]),
            .dout   (ch_out[c]),
            .dvalid (ch_v[c])
        );
    end

    assign i_out     = ch_out[0];
    assign q_out     = ch_out[1];
    assign out_valid = ch_v[0] & ch_v[1];

    // R5
    chan_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_v[0] == ch_v[1]);
endmodule

// File: tb/iq_interp2x_bench.sv
// Bench for iq_interp2x: directed corners plus seeded random bus traffic,
// compared every cycle with a requirement-level model.
module iq_interp2x_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 10;
    localparam int MAX_CYCLES = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         sel_i = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] i_out, q_out;
    logic         out_valid;

    int n_chk = 0;
    int n_fail = 0;

    // Model state
    int m_pend, m_ilat, m_pv, m_pi, m_pq, m_st;
    int li [4];
    int lq [4];
    int m_oi, m_oq, m_ov, m_ki, m_kq;

    iq_interp2x #(.DATA_W(W)) u_iq_interp2x (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .sel_i(sel_i),
        .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sx(logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    // R6/R7 reference: midpoint with rounding and saturation
    function automatic int mid4(int a0, int a1, int a2, int a3, output bit sat);
        int s;
        s = -a0 + 9*a1 + 9*a2 - a3 + 8;
        s = s >>> 4;
        sat = 1'b0;
        if (s > 511)  begin s = 511;  sat = 1'b1; end
        if (s < -512) begin s = -512; sat = 1'b1; end
        return s;
    endfunction

    task automatic check(string req, string ctx, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (ctx %s) %s actual=%0d expected=%0d", req, ctx, what, act, exp);
        end
    endtask

    function automatic string kind_tag(int k);
        case (k)
            1: return "R5";
            2: return "R6";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(string ctx);
        check("R5", ctx, "out_valid", int'(out_valid), m_ov);
        check(kind_tag(m_ki), ctx, "i_out", sx(i_out), m_oi);
        check(kind_tag(m_kq), ctx, "q_out", sx(q_out), m_oq);
    endtask

    task automatic model_reset();
        m_pend = 0; m_ilat = 0; m_pv = 0; m_pi = 0; m_pq = 0; m_st = 0;
        for (int k = 0; k < 4; k++) begin li[k] = 0; lq[k] = 0; end
        m_oi = 0; m_oq = 0; m_ov = 0; m_ki = 0; m_kq = 0;
    endtask

    // One clock edge of the requirement model, older stages first
    task automatic model_edge(int w, int s, int d);
        bit si, sq;
        if (m_st == 1) begin
            m_oi = li[2]; m_oq = lq[2]; m_ov = 1; m_ki = 1; m_kq = 1;
        end else if (m_st == 2) begin
            m_oi = mid4(li[0], li[1], li[2], li[3], si);
            m_oq = mid4(lq[0], lq[1], lq[2], lq[3], sq);
            m_ov = 1; m_ki = si ? 3 : 2; m_kq = sq ? 3 : 2;
        end else begin
            m_ov = 0; m_ki = 0; m_kq = 0;
        end
        m_st = (m_pv != 0) ? 1 : ((m_st == 1) ? 2 : 0);
        if (m_pv != 0) begin
            for (int k = 3; k > 0; k--) begin li[k] = li[k-1]; lq[k] = lq[k-1]; end
            li[0] = m_pi; lq[0] = m_pq;
        end
        m_pv = 0;
        if (w != 0) begin
            if (s != 0) begin m_ilat = d; m_pend = 1; end
            else if (m_pend != 0) begin m_pv = 1; m_pi = m_ilat; m_pq = d; m_pend = 0; end
        end
    endtask

    task automatic step(int w, int s, int d, string ctx);
        @(negedge clk);
        compare(ctx);
        wr_en = w[0]; sel_i = s[0]; din = W'(d);
        @(posedge clk);
        model_edge(w, s, sx(W'(d)));
    endtask

    task automatic pair(int iv, int qv, string ctx);
        step(1, 1, iv, ctx);
        step(1, 0, qv, ctx);
    endtask

    task automatic idle(int n, string ctx);
        for (int k = 0; k < n; k++) step(0, k & 1, 341 + k, ctx);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        // R1: state while reset held
        check("R1", "reset", "out_valid", int'(out_valid), 0);
        check("R1", "reset", "i_out", sx(i_out), 0);
        check("R1", "reset", "q_out", sx(q_out), 0);
        rst_n = 1'b1;
        @(posedge clk);
        model_edge(0, 0, 0);
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", MAX_CYCLES, MAX_CYCLES);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int sat_i [4];
        int sat_q [4];
        void'($urandom(32'd7321));
        model_reset();
        apply_reset();

        // R10 and R5: ramp of signed pairs
        for (int k = 0; k < 8; k++) pair(k * 37, -k * 21, "R10");
        idle(4, "R5");

        // R2: repeated I write, latest one kept
        step(1, 1, 100, "R2");
        step(1, 1, -200, "R2");
        step(1, 0, 50, "R2");
        pair(0, 0, "R2"); pair(0, 0, "R2");
        idle(4, "R2");

        // R3: stray Q words are discarded
        step(1, 0, 300, "R3");
        step(1, 0, -300, "R3");
        idle(4, "R3");
        pair(5, 6, "R3"); pair(0, 0, "R3"); pair(0, 0, "R3");
        idle(4, "R3");

        // R4: idle cycles with changing bus and select
        step(1, 1, 77, "R4");
        step(0, 1, 511, "R4");
        step(0, 0, -512, "R4");
        step(1, 0, -77, "R4");
        pair(0, 0, "R4"); pair(0, 0, "R4");
        idle(4, "R4");

        // R7: full-scale words push the midpoint into both rails
        sat_i = '{-512, 511, 511, -512};
        sat_q = '{511, -512, -512, 511};
        for (int k = 0; k < 4; k++) pair(sat_i[k], sat_q[k], "R7");
        idle(3, "R7");
        for (int k = 0; k < 4; k++) pair(sat_q[k], sat_i[k], "R7");
        idle(3, "R7");

        // R9: back-to-back random pairs, valid on every cycle
        for (int k = 0; k < 200; k++)
            pair(int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512, "R9");
        idle(4, "R9");

        // R1: reset in the middle of a stream, delay lines refill from zero
        for (int k = 0; k < 3; k++) pair(400 - k, -400 + k, "R1");
        apply_reset();
        for (int k = 0; k < 4; k++) pair(123, -321, "R1");
        idle(4, "R1");

        // Random mix of strobe, select and data
        for (int k = 0; k < 4000; k++)
            step(($urandom_range(0, 3) != 0) ? 1 : 0, int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 1023)), "R3");
        idle(4, "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule